// File: doc/BRIEF.md
# Single Load/Store Address Generator

This block works out where a single-register load or store goes and what its base register becomes. It takes the base register value, an offset source selection and the pieces each source needs: a 12-bit unsigned immediate, an 8-bit immediate delivered as two 4-bit halves, or an offset register that may be shifted by an immediate amount. It also takes a direction bit, an indexing bit, a writeback bit and the current carry flag.

The block returns the access address, the new base value and an enable for the base update. Pre-indexed accesses use the adjusted base as the address. Post-indexed accesses use the untouched base and always update it afterwards. The logic is purely combinational, so all three outputs follow the inputs in the same cycle. Memory access and data alignment belong to other blocks.

Top module: `lsag_addr_gen`

## Requirements
- R1: With `up_i`=1 the offset is added to the base; with `up_i`=0 it is subtracted. `new_base_o` always equals base plus or minus the offset, modulo 2^32.
- R2: With `pre_i`=1, `addr_o` equals `new_base_o`, and `base_we_o` equals `wback_i`.
- R3: With `pre_i`=0, `addr_o` equals `base_i` and `base_we_o` is 1 whatever `wback_i` is.
- R4: With `ofs_src_i`=0 the offset is `imm12_i` zero-extended, and the shift fields and carry have no effect.
- R5: With `ofs_src_i`=1 the offset is {`imm_hi_i`,`imm_lo_i`} zero-extended: the high half sits at bits 7:4 and the low half at bits 3:0.
- R6: With `ofs_src_i`=2 the offset is `offset_reg_i` unshifted, and the shift fields have no effect.
- R7: With `ofs_src_i`=3 and `shift_kind_i`=0, the offset is `offset_reg_i` shifted left by `shift_amt_i` (0 to 31). Kinds 5 to 7 behave the same way.
- R8: With kind 1 (logical right), the offset is `offset_reg_i` shifted right by `shift_amt_i`. An amount of 0 means a shift of 32, which gives 0.
- R9: With kind 2 (arithmetic right), bit 31 is copied into the vacated bits. An amount of 0 means a shift of 32, which gives 32 copies of bit 31.
- R10: With kind 3 (rotate right), the offset is `offset_reg_i` rotated right by `shift_amt_i`. An amount of 0 leaves it unrotated.
- R11: With kind 4 (extended rotate), the offset is `offset_reg_i` shifted right by one with `carry_i` placed at bit 31. `shift_amt_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| offset_reg_i | input | 32 | Offset register value |
| imm12_i | input | 12 | Unsigned 12-bit immediate offset |
| imm_hi_i | input | 4 | High half of the 8-bit immediate |
| imm_lo_i | input | 4 | Low half of the 8-bit immediate |
| ofs_src_i | input | 2 | Offset source: 0 imm12, 1 imm8, 2 register, 3 scaled register |
| shift_kind_i | input | 3 | Shift kind for the scaled offset: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| shift_amt_i | input | 5 | Immediate shift amount |
| carry_i | input | 1 | Current carry flag |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| wback_i | input | 1 | Writeback request for the pre-indexed form |
| addr_o | output | 32 | Effective access address |
| new_base_o | output | 32 | Updated base value |
| base_we_o | output | 1 | Base update enable |

## Verification
All three results are combinational and are due in the same cycle the inputs are applied, with no register on any path. The bench drives a new input set just after a rising clock edge and compares the outputs at the next falling edge, half a cycle later. By then the logic has settled, and no input change coincides with the sample.

// File: rtl/lsag_pkg.sv
// Package: shared encodings for the load/store address generator.
// Assumes: codes are fixed by the port contract in the brief.
package lsag_pkg;

    // Offset source selection
    typedef enum logic [1:0] {
        OFS_IMM12  = 2'd0,
        OFS_IMM8   = 2'd1,
        OFS_REG    = 2'd2,
        OFS_SCALED = 2'd3
    } ofs_src_t;

    // Shift kinds for the scaled register offset; unlisted codes act as left shift
    typedef enum logic [2:0] {
        SHK_LSL = 3'd0,
        SHK_LSR = 3'd1,
        SHK_ASR = 3'd2,
        SHK_ROR = 3'd3,
        SHK_RRX = 3'd4
    } shift_kind_t;

endpackage

// File: rtl/lsag_shifter.sv
// Module: lsag_shifter
// Purpose: scales the offset register by an immediate amount using one of
//          five shift kinds.
// Assumes: DATA_W is a power of two; an amount of 0 on a right shift or an
//          arithmetic right shift stands for a shift of DATA_W.
module lsag_shifter
    import lsag_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  opnd_i,
    input  logic [2:0]         kind_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  result_o
);

    localparam logic [SHAMT_W:0] FULL_AMT = (SHAMT_W+1)'(DATA_W);

    logic [SHAMT_W:0]   inv_amt;
    logic [DATA_W-1:0]  lsl_v, lsr_v, asr_v, ror_v, rrx_v;

    // Compute every shift kind in parallel
    always_comb begin
        inv_amt = FULL_AMT - {1'b0, amt_i};
        lsl_v   = opnd_i << amt_i;
        lsr_v   = (amt_i == '0) ? '0 : (opnd_i >> amt_i);
        asr_v   = (amt_i == '0) ? {DATA_W{opnd_i[DATA_W-1]}}
                                : DATA_W'($signed(opnd_i) >>> amt_i);
        ror_v   = (amt_i == '0) ? opnd_i
                                : ((opnd_i >> amt_i) | (opnd_i << inv_amt));
        rrx_v   = {carry_i, opnd_i[DATA_W-1:1]};
    end

    // Pick the result for the requested kind
    always_comb begin
        unique case (kind_i)
            SHK_LSR: result_o = lsr_v;
            SHK_ASR: result_o = asr_v;
            SHK_ROR: result_o = ror_v;
            SHK_RRX: result_o = rrx_v;
            default: result_o = lsl_v;
        endcase
    end

    // Guards on the shifter output
    always_comb begin
        // R11
        rrx_carry_chk: assert (kind_i != SHK_RRX || result_o[DATA_W-1] == carry_i)
            else $error("extended rotate lost the carry");
        // R8
        lsr_full_chk: assert (!(kind_i == SHK_LSR && amt_i == '0) || result_o == '0)
            else $error("logical right shift by full width not zero");
        // R9
        asr_full_chk: assert (!(kind_i == SHK_ASR && amt_i == '0) ||
                              result_o == {DATA_W{opnd_i[DATA_W-1]}})
            else $error("arithmetic right shift by full width not sign fill");
    end

endmodule

// File: rtl/lsag_offset_sel.sv
// Module: lsag_offset_sel
// Purpose: chooses the offset from the 12-bit immediate, the split 8-bit
//          immediate, the raw register or the scaled register.
// Assumes: immediates are unsigned and zero-extended to DATA_W.
module lsag_offset_sel
    import lsag_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM12_W = 12,
    parameter int NIB_W   = 4
) (
    input  logic [1:0]         src_i,
    input  logic [IMM12_W-1:0] imm12_i,
    input  logic [NIB_W-1:0]   imm_hi_i,
    input  logic [NIB_W-1:0]   imm_lo_i,
    input  logic [DATA_W-1:0]  reg_i,
    input  logic [DATA_W-1:0]  scaled_i,
    output logic [DATA_W-1:0]  offset_o
);

    localparam int IMM8_W = 2 * NIB_W;

    // Route the selected offset source
    always_comb begin
        unique case (src_i)
            OFS_IMM12: offset_o = {{(DATA_W-IMM12_W){1'b0}}, imm12_i};
            OFS_IMM8:  offset_o = {{(DATA_W-IMM8_W){1'b0}}, imm_hi_i, imm_lo_i};
            OFS_REG:   offset_o = reg_i;
            default:   offset_o = scaled_i;
        endcase
    end

    // Guards on immediate widths
    always_comb begin
        // R5
        imm8_width_chk: assert (src_i != OFS_IMM8 || offset_o[DATA_W-1:IMM8_W] == '0)
            else $error("8-bit immediate offset has upper bits set");
        // R4
        imm12_width_chk: assert (src_i != OFS_IMM12 || offset_o[DATA_W-1:IMM12_W] == '0)
            else $error("12-bit immediate offset has upper bits set");
    end

endmodule

// File: rtl/lsag_index_unit.sv
// Module: lsag_index_unit
// Purpose: applies the offset in the chosen direction and picks the access
//          address and base update for pre- or post-indexing.
// Assumes: arithmetic wraps modulo 2^DATA_W.
module lsag_index_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic              up_i,
    input  logic              pre_i,
    input  logic              wback_i,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] new_base_o,
    output logic              base_we_o
);

    logic [DATA_W-1:0] sum_v;

    // Add or subtract the offset
    always_comb begin
        sum_v = up_i ? (base_i + offset_i) : (base_i - offset_i);
    end

    // Select the address and write-back behaviour
    always_comb begin
        new_base_o = sum_v;
        addr_o     = pre_i ? sum_v : base_i;
        base_we_o  = pre_i ? wback_i : 1'b1;
    end

    // Guards on indexing behaviour
    always_comb begin
        // R3
        post_update_chk: assert (pre_i || (base_we_o && addr_o == base_i))
            else $error("post-indexed access wrong");
        // R2
        pre_addr_chk: assert (!pre_i || (addr_o == new_base_o && base_we_o == wback_i))
            else $error("pre-indexed access wrong");
        // R1
        direction_chk: assert (( up_i && (new_base_o - base_i) == offset_i) ||
                               (!up_i && (base_i - new_base_o) == offset_i))
            else $error("base adjustment direction wrong");
    end

endmodule

// File: rtl/lsag_addr_gen.sv
// Module: lsag_addr_gen
// Purpose: top of the single load/store address generator; connects the
//          shifter, offset selector and indexing unit.
// Assumes: fully combinational; outputs follow inputs in the same cycle.
module lsag_addr_gen #(
    parameter int DATA_W  = 32,
    parameter int IMM12_W = 12,
    parameter int NIB_W   = 4,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  base_i,
    input  logic [DATA_W-1:0]  offset_reg_i,
    input  logic [IMM12_W-1:0] imm12_i,
    input  logic [NIB_W-1:0]   imm_hi_i,
    input  logic [NIB_W-1:0]   imm_lo_i,
    input  logic [1:0]         ofs_src_i,
    input  logic [2:0]         shift_kind_i,
    input  logic [SHAMT_W-1:0] shift_amt_i,
    input  logic               carry_i,
    input  logic               up_i,
    input  logic               pre_i,
    input  logic               wback_i,
    output logic [DATA_W-1:0]  addr_o,
    output logic [DATA_W-1:0]  new_base_o,
    output logic               base_we_o
);

    logic [DATA_W-1:0] scaled_w;
    logic [DATA_W-1:0] offset_w;

    lsag_shifter #(
        .DATA_W  (DATA_W),
        .SHAMT_W (SHAMT_W)
    ) u_shift (
        .opnd_i   (offset_reg_i),
        .kind_i   (shift_kind_i),
        .amt_i    (shift_amt_i),
        .carry_i  (carry_i),
        .result_o (scaled_w)
    );

    lsag_offset_sel #(
        .DATA_W  (DATA_W),
        .IMM12_W (IMM12_W),
        .NIB_W   (NIB_W)
    ) u_sel (
        .src_i    (ofs_src_i),
        .imm12_i  (imm12_i),
        .imm_hi_i (imm_hi_i),
        .imm_lo_i (imm_lo_i),
        .reg_i    (offset_reg_i),
        .scaled_i (scaled_w),
        .offset_o (offset_w)
    );

    lsag_index_unit #(
        .DATA_W (DATA_W)
    ) u_idx (
        .base_i     (base_i),
        .offset_i   (offset_w),
        .up_i       (up_i),
        .pre_i      (pre_i),
        .wback_i    (wback_i),
        .addr_o     (addr_o),
        .new_base_o (new_base_o),
        .base_we_o  (base_we_o)
    );

    // Guard: the raw register source passes the register through unchanged
    always_comb begin
        // R6
        raw_reg_chk: assert (ofs_src_i != 2'd2 || offset_w == offset_reg_i)
            else $error("raw register offset altered");
    end

endmodule

// File: tb/lsag_addr_gen_test.sv
// Bench for lsag_addr_gen: vector table followed by directed sweeps.
module lsag_addr_gen_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] base_i, offset_reg_i;
    logic [11:0] imm12_i;
    logic [3:0]  imm_hi_i, imm_lo_i;
    logic [1:0]  ofs_src_i;
    logic [2:0]  shift_kind_i;
    logic [4:0]  shift_amt_i;
    logic        carry_i, up_i, pre_i, wback_i;
    logic [31:0] addr_o, new_base_o;
    logic        base_we_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lsag_addr_gen uut (
        .base_i(base_i), .offset_reg_i(offset_reg_i), .imm12_i(imm12_i),
        .imm_hi_i(imm_hi_i), .imm_lo_i(imm_lo_i), .ofs_src_i(ofs_src_i),
        .shift_kind_i(shift_kind_i), .shift_amt_i(shift_amt_i), .carry_i(carry_i),
        .up_i(up_i), .pre_i(pre_i), .wback_i(wback_i),
        .addr_o(addr_o), .new_base_o(new_base_o), .base_we_o(base_we_o)
    );

    typedef struct packed {
        logic [31:0] tag;
        logic [1:0]  src;
        logic [2:0]  kind;
        logic [4:0]  amt;
        logic        c, u, p, w;
        logic [31:0] base, rg;
        logic [11:0] i12;
        logic [3:0]  hi, lo;
        logic [31:0] ea, enb;
        logic        ewe;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{"R4  ",2'd0,3'd0,5'd0,1'b0,1'b1,1'b1,1'b0,32'h40000004,32'h4,12'h004,4'h0,4'h0,32'h40000008,32'h40000008,1'b0},
        '{"R2  ",2'd0,3'd0,5'd0,1'b0,1'b1,1'b1,1'b1,32'h40000004,32'h4,12'h004,4'h0,4'h0,32'h40000008,32'h40000008,1'b1},
        '{"R3  ",2'd0,3'd0,5'd0,1'b0,1'b1,1'b0,1'b0,32'h40000004,32'h4,12'h004,4'h0,4'h0,32'h40000004,32'h40000008,1'b1},
        '{"R1  ",2'd0,3'd0,5'd0,1'b0,1'b0,1'b1,1'b1,32'h40000004,32'h4,12'hFFF,4'h0,4'h0,32'h3FFFF005,32'h3FFFF005,1'b1},
        '{"R1  ",2'd0,3'd0,5'd0,1'b0,1'b0,1'b1,1'b0,32'h00000002,32'h4,12'h004,4'h0,4'h0,32'hFFFFFFFE,32'hFFFFFFFE,1'b0},
        '{"R5  ",2'd1,3'd0,5'd0,1'b0,1'b1,1'b1,1'b0,32'h40000004,32'h4,12'h000,4'hA,4'h5,32'h400000A9,32'h400000A9,1'b0},
        '{"R6  ",2'd2,3'd0,5'd3,1'b0,1'b0,1'b0,1'b1,32'h40000004,32'h4,12'h000,4'h0,4'h0,32'h40000004,32'h40000000,1'b1},
        '{"R7  ",2'd3,3'd0,5'd1,1'b1,1'b1,1'b1,1'b0,32'h40000004,32'h4,12'h000,4'h0,4'h0,32'h4000000C,32'h4000000C,1'b0},
        '{"R7  ",2'd3,3'd0,5'd31,1'b0,1'b1,1'b1,1'b0,32'h40000004,32'h3,12'h000,4'h0,4'h0,32'hC0000004,32'hC0000004,1'b0},
        '{"R8  ",2'd3,3'd1,5'd1,1'b0,1'b1,1'b1,1'b0,32'h40000004,32'h4,12'h000,4'h0,4'h0,32'h40000006,32'h40000006,1'b0},
        '{"R8  ",2'd3,3'd1,5'd0,1'b0,1'b1,1'b1,1'b0,32'h40000004,32'hFFFFFFFF,12'h000,4'h0,4'h0,32'h40000004,32'h40000004,1'b0},
        '{"R9  ",2'd3,3'd2,5'd0,1'b0,1'b1,1'b1,1'b0,32'h40000004,32'h80000000,12'h000,4'h0,4'h0,32'h40000003,32'h40000003,1'b0},
        '{"R9  ",2'd3,3'd2,5'd4,1'b0,1'b1,1'b1,1'b0,32'h00000000,32'h80000010,12'h000,4'h0,4'h0,32'hF8000001,32'hF8000001,1'b0},
        '{"R10 ",2'd3,3'd3,5'd1,1'b0,1'b1,1'b1,1'b0,32'h00000000,32'h3,12'h000,4'h0,4'h0,32'h80000001,32'h80000001,1'b0},
        '{"R10 ",2'd3,3'd3,5'd0,1'b0,1'b1,1'b1,1'b0,32'h00000000,32'h12345678,12'h000,4'h0,4'h0,32'h12345678,32'h12345678,1'b0},
        '{"R11 ",2'd3,3'd4,5'd0,1'b1,1'b1,1'b1,1'b0,32'h00000000,32'h4,12'h000,4'h0,4'h0,32'h80000002,32'h80000002,1'b0},
        '{"R11 ",2'd3,3'd4,5'd7,1'b0,1'b1,1'b1,1'b0,32'h00000000,32'h5,12'h000,4'h0,4'h0,32'h00000002,32'h00000002,1'b0},
        '{"R7  ",2'd3,3'd5,5'd2,1'b0,1'b1,1'b1,1'b0,32'h00000000,32'h1,12'h000,4'h0,4'h0,32'h00000004,32'h00000004,1'b0},
        '{"R4  ",2'd0,3'd3,5'd9,1'b1,1'b1,1'b0,1'b1,32'h00001000,32'h4,12'hABC,4'h0,4'h0,32'h00001000,32'h00001ABC,1'b1}
    };

    task automatic apply(input vec_t v);
        @(posedge clk);
        #1;
        ofs_src_i = v.src; shift_kind_i = v.kind; shift_amt_i = v.amt;
        carry_i = v.c; up_i = v.u; pre_i = v.p; wback_i = v.w;
        base_i = v.base; offset_reg_i = v.rg; imm12_i = v.i12;
        imm_hi_i = v.hi; imm_lo_i = v.lo;
    endtask

    task automatic expect_out(input logic [31:0] tag, input logic [31:0] ea,
                              input logic [31:0] enb, input logic ewe);
        @(negedge clk);
        checks++;
        if (addr_o !== ea || new_base_o !== enb || base_we_o !== ewe) begin
            errors++;
            $display("FAIL %s: addr=%h base=%h we=%b expected addr=%h base=%h we=%b",
                     tag, addr_o, new_base_o, base_we_o, ea, enb, ewe);
        end
    endtask

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        base_i = '0; offset_reg_i = '0; imm12_i = '0; imm_hi_i = '0; imm_lo_i = '0;
        ofs_src_i = '0; shift_kind_i = '0; shift_amt_i = '0;
        carry_i = 0; up_i = 0; pre_i = 0; wback_i = 0;
        repeat (3) @(posedge clk);
        // Reset state with idle inputs: post-indexed, zero offset (R3)
        expect_out("R3  ", 32'h0, 32'h0, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            expect_out(VECS[i].tag, VECS[i].ea, VECS[i].enb, VECS[i].ewe);
        end

        // R7: left shift sweep of a single bit
        for (int a = 0; a < 32; a++) begin
            apply('{"R7  ",2'd3,3'd0,5'(a),1'b1,1'b1,1'b1,1'b1,32'h0,32'h1,12'h0,4'h0,4'h0,32'h0,32'h0,1'b0});
            expect_out("R7  ", 32'h1 << a, 32'h1 << a, 1'b1);
        end

        // R10: rotate sweep of a pattern
        for (int a = 1; a < 32; a++) begin
            apply('{"R10 ",2'd3,3'd3,5'(a),1'b0,1'b1,1'b0,1'b0,32'h0,32'h000000F1,12'h0,4'h0,4'h0,32'h0,32'h0,1'b0});
            expect_out("R10 ", 32'h0, (32'h000000F1 >> a) | (32'h000000F1 << (32 - a)), 1'b1);
        end

        // R8: logical right sweep with down direction from a fixed base
        for (int a = 1; a < 32; a++) begin
            apply('{"R8  ",2'd3,3'd1,5'(a),1'b1,1'b0,1'b1,1'b0,32'h80000000,32'h80000000,12'h0,4'h0,4'h0,32'h0,32'h0,1'b0});
            expect_out("R8  ", 32'h80000000 - (32'h80000000 >> a),
                       32'h80000000 - (32'h80000000 >> a), 1'b0);
        end

        // R6: shift fields have no effect on the raw register source
        apply('{"R6  ",2'd2,3'd4,5'd17,1'b1,1'b1,1'b1,1'b1,32'h10,32'h80000001,12'h0,4'h0,4'h0,32'h0,32'h0,1'b0});
        expect_out("R6  ", 32'h80000011, 32'h80000011, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule